// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Access Controller

This block fronts a small direct-mapped, write-back cache that several requesters share through one request port. Each request carries a requester number, an operation (read or write, one word or a whole line), a word address and write data. The cache belongs to one requester at a time. The first requester to arrive while the cache is free takes it. Any other requester is turned away with a WAIT code until the owner has finished.

For the owning requester, the controller first checks for a miss. On a miss it starts a line fill from backing memory. If the victim line is dirty, it is written back before the new line is read. While the fill is in flight the owner gets BLOCKED. After that, a fixed hit latency is counted down, and the access completes with OK. Read data is presented together with the OK code. Ownership is then released, so that another requester can take the cache on the next cycle.

The backing memory port is a plain request/acknowledge interface that moves one line per transfer.

Top module: `cache_access_ctrl`

## Requirements
- R1: A valid request made while no requester owns the cache claims ownership in that cycle. It is evaluated in the same cycle, so a cold miss gets BLOCKED as its very first response, not WAIT.
- R2: A request from a requester that is not the current owner gets WAIT and changes no state. A write made this way leaves the cached data unchanged.
- R3: For the owner, a miss (line invalid, or stored tag differs) starts a fill and answers BLOCKED. Every owner cycle while the fill is outstanding also answers BLOCKED, and OK is never given in such a cycle.
- R4: When ownership is claimed, a latency counter is loaded with HIT_LAT, and it decrements once per cycle while the cache is owned. A hit answers WAIT until the counter is zero. A hit from a free cache therefore gives exactly HIT_LAT WAIT responses and then OK, and cycles spent on other requesters still count down.
- R5: The word address is split from the least significant bit upward into offset (log2 LINE_WORDS bits), index (log2 LINES bits) and tag (the remaining bits). Two addresses with the same index and different tags evict each other. Addresses with different indexes do not.
- R6: On a miss to a dirty line, the victim is written to memory line address {old tag, index} with mem_we=1. Only after that is the new line read from {new tag, index} with mem_we=0. A miss to a clean line does only the read. A fetched line is stored valid and clean.
- R7: A word write changes only the addressed word of the indexed line. A line write replaces all words of the line. Both kinds of write mark the line dirty, so it is written back on eviction.
- R8: A word read returns the addressed word on rd_word in the cycle its OK code is shown. A line read returns the whole line on rd_line in that cycle, with the word at offset k in bits [k*WORD_W +: WORD_W].
- R9: Ownership is released in the cycle OK is issued, so a different requester can claim the cache on the very next cycle.
- R10: rsp_code is registered and reflects the request seen at the previous clock edge. The encoding is 0 = no request, 1 = OK, 2 = WAIT, 3 = BLOCKED. The operation encoding is 0 = word read, 1 = line read, 2 = word write, 3 = line write. After reset rsp_code is 0 and mem_req is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_id | input | ID_W | Number of the requester presenting |
| req_op | input | 2 | Operation code (R10) |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | WORD_W | Data for a word write |
| req_wline | input | LINE_BITS | Data for a line write |
| rsp_code | output | 2 | Registered response code |
| rd_word | output | WORD_W | Word read data, valid with OK |
| rd_line | output | LINE_BITS | Line read data, valid with OK |
| mem_req | output | 1 | Memory transfer requested |
| mem_we | output | 1 | Transfer is a write-back |
| mem_addr | output | ADDR_W-OFF_W | Memory line address |
| mem_wline | output | LINE_BITS | Line being written back |
| mem_rline | input | LINE_BITS | Line returned by memory, valid with ack |
| mem_ack | input | 1 | One-cycle transfer completion |

## Verification
The bench sweeps word writes and read-backs over three tags that collide on every index, then forces a full eviction and compares the memory image against its own arithmetic model. A design that skipped or reordered the write-back would leave stale lines in memory or return wrong data after a refetch. Contention is probed by slipping a second requester's write in while a fill is outstanding, and by slipping a third requester in during the owner's latency countdown. A design that let the intruder in would corrupt the line or finish early. A design that stopped counting while the intruder was waiting would take one cycle too many. The bench also counts the WAIT responses of a plain hit and logs the exact order of memory transfers for dirty and clean evictions. Off-by-one latency errors and a missing dirty bit therefore show up directly.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [1:0] {
    OP_RD_WORD = 2'd0,
    OP_RD_LINE = 2'd1,
    OP_WR_WORD = 2'd2,
    OP_WR_LINE = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    RSP_NONE    = 2'd0,
    RSP_OK      = 2'd1,
    RSP_WAIT    = 2'd2,
    RSP_BLOCKED = 2'd3
  } rsp_e;

  typedef enum logic [1:0] {
    FS_IDLE  = 2'd0,
    FS_WB    = 2'd1,
    FS_FETCH = 2'd2
  } fill_st_e;
endpackage

// File: rtl/cc_addr_split.sv
module cc_addr_split #(
  parameter int ADDR_W = 10,
  parameter int OFF_W  = 2,
  parameter int IDX_W  = 3,
  parameter int TAG_W  = ADDR_W - OFF_W - IDX_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [OFF_W-1:0]  off,
  output logic [IDX_W-1:0]  idx,
  output logic [TAG_W-1:0]  tag
);
  // offset in the low bits, index above it, tag on top
  assign off = addr[OFF_W-1:0];
  assign idx = addr[OFF_W +: IDX_W];
  assign tag = addr[ADDR_W-1 -: TAG_W];
endmodule

// File: rtl/cc_owner_lock.sv
module cc_owner_lock #(
  parameter int NREQ    = 3,
  parameter int HIT_LAT = 2,
  parameter int ID_W    = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [ID_W-1:0] req_id,
  input  logic            grant_ok,
  output logic            owner_valid,
  output logic            cleared,
  output logic            lat_done
);
  localparam int CNT_W = (HIT_LAT > 0) ? $clog2(HIT_LAT + 1) : 1;

  logic            own_q;
  logic [ID_W-1:0] own_id_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] eff;
  logic             claim;

  assign claim       = req_valid && !own_q;
  assign cleared     = req_valid && (!own_q || (req_id == own_id_q));
  assign eff         = own_q ? cnt_q : CNT_W'(HIT_LAT);
  assign lat_done    = (eff == '0);
  assign owner_valid = own_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      own_q    <= 1'b0;
      own_id_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (grant_ok) begin
        own_q <= 1'b0;
      end else if (claim) begin
        own_q    <= 1'b1;
        own_id_q <= req_id;
      end
      if (claim || own_q) begin
        cnt_q <= lat_done ? '0 : eff - 1'b1;
      end
    end
  end

  AST_OWNER_HOLD: assert property (@(posedge clk) disable iff (rst)
    own_q && !grant_ok |=> own_q && $stable(own_id_q)); // R1
  AST_RELEASE_ON_OK: assert property (@(posedge clk) disable iff (rst)
    grant_ok |=> !own_q); // R9
  AST_LAT_STEP: assert property (@(posedge clk) disable iff (rst)
    own_q && (cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1); // R4
endmodule

// File: rtl/cc_fill_ctrl.sv
module cc_fill_ctrl
  import cache_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int TAG_W = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   miss_start,
  input  logic                   victim_dirty,
  input  logic [IDX_W-1:0]       miss_idx,
  input  logic [TAG_W-1:0]       victim_tag,
  input  logic [TAG_W-1:0]       miss_tag,
  input  logic                   mem_ack,
  output logic                   busy,
  output logic                   done,
  output logic [IDX_W-1:0]       fill_idx,
  output logic [TAG_W-1:0]       fill_tag,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [TAG_W+IDX_W-1:0] mem_line_addr
);
  fill_st_e         st_q;
  logic [IDX_W-1:0] idx_q;
  logic [TAG_W-1:0] new_tag_q;
  logic [TAG_W-1:0] old_tag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= FS_IDLE;
      idx_q     <= '0;
      new_tag_q <= '0;
      old_tag_q <= '0;
    end else begin
      case (st_q)
        FS_IDLE: if (miss_start) begin
          idx_q     <= miss_idx;
          new_tag_q <= miss_tag;
          old_tag_q <= victim_tag;
          st_q      <= victim_dirty ? FS_WB : FS_FETCH;
        end
        FS_WB:    if (mem_ack) st_q <= FS_FETCH;
        FS_FETCH: if (mem_ack) st_q <= FS_IDLE;
        default:  st_q <= FS_IDLE;
      endcase
    end
  end

  assign busy          = (st_q != FS_IDLE);
  assign done          = (st_q == FS_FETCH) && mem_ack;
  assign fill_idx      = idx_q;
  assign fill_tag      = new_tag_q;
  assign mem_req       = busy;
  assign mem_we        = (st_q == FS_WB);
  assign mem_line_addr = (st_q == FS_WB) ? {old_tag_q, idx_q} : {new_tag_q, idx_q};

  AST_WB_THEN_FETCH: assert property (@(posedge clk) disable iff (rst)
    (st_q == FS_WB) && mem_ack |=> (st_q == FS_FETCH)); // R6
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    busy |-> !miss_start); // R3
endmodule

// File: rtl/cc_line_store.sv
module cc_line_store #(
  parameter int LINES      = 8,
  parameter int LINE_WORDS = 4,
  parameter int WORD_W     = 16,
  parameter int IDX_W      = $clog2(LINES)
) (
  input  logic                         clk,
  input  logic [LINE_WORDS-1:0]        we_lane,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [LINE_WORDS*WORD_W-1:0] wr_line,
  input  logic [IDX_W-1:0]             rd_idx,
  output logic [LINE_WORDS*WORD_W-1:0] rd_line
);
  // one simple dual-port memory per word lane, synchronous read
  for (genvar l = 0; l < LINE_WORDS; l++) begin : g_lane
    logic [WORD_W-1:0] mem [LINES];
    logic [WORD_W-1:0] rd_q;
    always_ff @(posedge clk) begin
      if (we_lane[l]) mem[wr_idx] <= wr_line[l*WORD_W +: WORD_W];
      rd_q <= mem[rd_idx];
    end
    assign rd_line[l*WORD_W +: WORD_W] = rd_q;
  end
endmodule

// File: rtl/cache_access_ctrl.sv
module cache_access_ctrl
  import cache_pkg::*;
#(
  parameter int NREQ       = 3,
  parameter int ADDR_W     = 10,
  parameter int WORD_W     = 16,
  parameter int LINE_WORDS = 4,
  parameter int LINES      = 8,
  parameter int HIT_LAT    = 2,
  localparam int ID_W      = (NREQ > 1) ? $clog2(NREQ) : 1,
  localparam int OFF_W     = $clog2(LINE_WORDS),
  localparam int LINE_BITS = LINE_WORDS * WORD_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic [ID_W-1:0]         req_id,
  input  logic [1:0]              req_op,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [WORD_W-1:0]       req_wdata,
  input  logic [LINE_BITS-1:0]    req_wline,
  output logic [1:0]              rsp_code,
  output logic [WORD_W-1:0]       rd_word,
  output logic [LINE_BITS-1:0]    rd_line,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [ADDR_W-OFF_W-1:0] mem_addr,
  output logic [LINE_BITS-1:0]    mem_wline,
  input  logic [LINE_BITS-1:0]    mem_rline,
  input  logic                    mem_ack
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  op_e              op;
  logic [OFF_W-1:0] off;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;

  logic [TAG_W-1:0] tag_q [LINES];
  logic [LINES-1:0] vld_q;
  logic [LINES-1:0] dty_q;

  logic owner_valid, cleared, lat_done;
  logic fill_busy, fill_done;
  logic [IDX_W-1:0] fill_idx;
  logic [TAG_W-1:0] fill_tag;

  logic hit, is_wr, ok_fire, miss_start;
  rsp_e rsp_d, rsp_q;
  logic [OFF_W-1:0] off_q;

  logic [LINE_WORDS-1:0] we_lane;
  logic [IDX_W-1:0]      wr_idx, rd_idx;
  logic [LINE_BITS-1:0]  wr_line, line_rd;

  assign op = op_e'(req_op);

  cc_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_split (
    .addr(req_addr), .off(off), .idx(idx), .tag(tag)
  );

  cc_owner_lock #(.NREQ(NREQ), .HIT_LAT(HIT_LAT), .ID_W(ID_W)) u_lock (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_id(req_id),
    .grant_ok(ok_fire), .owner_valid(owner_valid), .cleared(cleared),
    .lat_done(lat_done)
  );

  cc_fill_ctrl #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_fill (
    .clk(clk), .rst(rst), .miss_start(miss_start), .victim_dirty(dty_q[idx]),
    .miss_idx(idx), .victim_tag(tag_q[idx]), .miss_tag(tag), .mem_ack(mem_ack),
    .busy(fill_busy), .done(fill_done), .fill_idx(fill_idx), .fill_tag(fill_tag),
    .mem_req(mem_req), .mem_we(mem_we), .mem_line_addr(mem_addr)
  );

  assign hit   = vld_q[idx] && (tag_q[idx] == tag);
  assign is_wr = (op == OP_WR_WORD) || (op == OP_WR_LINE);

  // access check: lock, then miss handling, then latency
  always_comb begin
    rsp_d      = RSP_NONE;
    ok_fire    = 1'b0;
    miss_start = 1'b0;
    if (req_valid) begin
      if (!cleared) begin
        rsp_d = RSP_WAIT;
      end else if (fill_busy) begin
        rsp_d = RSP_BLOCKED;
      end else if (!hit) begin
        rsp_d      = RSP_BLOCKED;
        miss_start = 1'b1;
      end else if (lat_done) begin
        rsp_d   = RSP_OK;
        ok_fire = 1'b1;
      end else begin
        rsp_d = RSP_WAIT;
      end
    end
  end

  // data store write port: fill has priority (never overlaps an OK)
  always_comb begin
    we_lane = '0;
    wr_idx  = idx;
    wr_line = {LINE_WORDS{req_wdata}};
    if (fill_done) begin
      we_lane = '1;
      wr_idx  = fill_idx;
      wr_line = mem_rline;
    end else if (ok_fire && op == OP_WR_LINE) begin
      we_lane = '1;
      wr_line = req_wline;
    end else if (ok_fire && op == OP_WR_WORD) begin
      we_lane[off] = 1'b1;
    end
  end

  assign rd_idx = fill_busy ? fill_idx : idx;

  cc_line_store #(.LINES(LINES), .LINE_WORDS(LINE_WORDS), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .we_lane(we_lane), .wr_idx(wr_idx), .wr_line(wr_line),
    .rd_idx(rd_idx), .rd_line(line_rd)
  );

  always_ff @(posedge clk) begin
    if (fill_done) tag_q[fill_idx] <= fill_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      dty_q <= '0;
      rsp_q <= RSP_NONE;
      off_q <= '0;
    end else begin
      rsp_q <= rsp_d;
      off_q <= off;
      if (fill_done) begin
        vld_q[fill_idx] <= 1'b1;
        dty_q[fill_idx] <= 1'b0;
      end else if (ok_fire && is_wr) begin
        dty_q[idx] <= 1'b1;
      end
    end
  end

  assign rsp_code  = rsp_q;
  assign rd_line   = line_rd;
  assign rd_word   = line_rd[off_q*WORD_W +: WORD_W];
  assign mem_wline = line_rd;

  AST_STRANGER_WAITS: assert property (@(posedge clk) disable iff (rst)
    req_valid && owner_valid && !cleared |=> rsp_code == RSP_WAIT); // R2
  AST_OK_NEEDS_IDLE_FILL: assert property (@(posedge clk) disable iff (rst)
    rsp_code == RSP_OK |-> !$past(fill_busy)); // R3
  AST_FILL_CLEAN: assert property (@(posedge clk) disable iff (rst)
    fill_done |=> vld_q[$past(fill_idx)] && !dty_q[$past(fill_idx)]); // R6
  AST_WRITE_DIRTY: assert property (@(posedge clk) disable iff (rst)
    ok_fire && is_wr |=> dty_q[$past(idx)]); // R7
endmodule

// File: tb/cache_access_ctrl_tb.sv
module cache_access_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HIT_LAT    = 2;
  localparam int MEM_LAT    = 3;
  localparam int WORDS      = 1024;
  localparam int MLINES     = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_id = '0;
  logic [1:0]  req_op = '0;
  logic [9:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [63:0] req_wline = '0;
  logic [1:0]  rsp_code;
  logic [15:0] rd_word;
  logic [63:0] rd_line;
  logic        mem_req, mem_we;
  logic [7:0]  mem_addr;
  logic [63:0] mem_wline;
  logic [63:0] mem_rline = '0;
  logic        mem_ack = 1'b0;

  int total = 0;
  int bad   = 0;

  logic [15:0] exp_w   [WORDS];
  logic [63:0] model_m [MLINES];
  int          mcnt = 0;
  int          log_n = 0;
  logic        log_we   [8];
  logic [7:0]  log_addr [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_access_ctrl #(.HIT_LAT(HIT_LAT)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_id(req_id), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_wline(req_wline),
    .rsp_code(rsp_code), .rd_word(rd_word), .rd_line(rd_line),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wline(mem_wline),
    .mem_rline(mem_rline), .mem_ack(mem_ack)
  );

  function automatic logic [15:0] pat(input int a);
    return 16'(a * 73 + 11);
  endfunction

  function automatic logic [63:0] exp_line(input int a);
    logic [63:0] l;
    int b = a & ~3;
    for (int w = 0; w < 4; w++) l[w*16 +: 16] = exp_w[b + w];
    return l;
  endfunction

  // backing memory: fixed latency, one-cycle ack
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      mcnt    = 0;
    end else if (mem_req) begin
      if (mcnt == MEM_LAT) begin
        mem_ack = 1'b1;
        if (mem_we) model_m[mem_addr] = mem_wline;
        else        mem_rline = model_m[mem_addr];
        if (log_n < 8) begin
          log_we[log_n]   = mem_we;
          log_addr[log_n] = mem_addr;
        end
        log_n++;
      end else begin
        mcnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, expv);
    end
  endtask

  task automatic drive(input int id, input int op, input int addr, input logic [15:0] wd, input logic [63:0] wl);
    req_valid = 1'b1;
    req_id    = 2'(id);
    req_op    = 2'(op);
    req_addr  = 10'(addr);
    req_wdata = wd;
    req_wline = wl;
  endtask

  task automatic step(output logic [1:0] c);
    @(posedge clk);
    @(negedge clk);
    c = rsp_code;
  endtask

  task automatic finish_acc(input int op, input int addr, input logic [15:0] wd,
                            input logic [63:0] wl, output int nw, output int nb);
    logic [1:0] c;
    bit okd = 0;
    nw = 0; nb = 0;
    for (int k = 0; k < 400; k++) begin
      step(c);
      if (c == 2'd1) begin okd = 1; break; end
      else if (c == 2'd2) nw++;
      else if (c == 2'd3) nb++;
    end
    req_valid = 1'b0;
    if (!okd) chk(0, "R3 access never completed", 64'(c), 64'd1);
    if (op == 2) exp_w[addr] = wd;
    if (op == 3) for (int w = 0; w < 4; w++) exp_w[(addr & ~3) + w] = wl[w*16 +: 16];
  endtask

  task automatic acc(input int id, input int op, input int addr, input logic [15:0] wd,
                     input logic [63:0] wl, output int nw, output int nb);
    drive(id, op, addr, wd, wl);
    finish_acc(op, addr, wd, wl, nw, nb);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int nw, nb;
    logic [1:0] c;
    for (int a = 0; a < WORDS; a++) exp_w[a] = pat(a);
    for (int l = 0; l < MLINES; l++)
      for (int w = 0; w < 4; w++) model_m[l][w*16 +: 16] = pat(l*4 + w);

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rsp_code == 2'd0, "R10 reset rsp", 64'(rsp_code), 0);
    chk(mem_req == 1'b0, "R10 reset mem_req", 64'(mem_req), 0);

    // R1: cold miss from a free cache answers BLOCKED first
    drive(0, 0, 10'h045, 0, 0);
    step(c);
    chk(c == 2'd3, "R1 first response of cold miss", 64'(c), 3);
    finish_acc(0, 10'h045, 0, 0, nw, nb);
    chk(rd_word == exp_w[10'h045], "R8 word read after fill", 64'(rd_word), 64'(exp_w[10'h045]));
    step(c);
    chk(c == 2'd0, "R10 idle response", 64'(c), 0);

    // R4: hit from a free cache
    acc(0, 1, 10'h046, 0, 0, nw, nb);
    chk(nw == HIT_LAT && nb == 0, "R4 hit latency", 64'(nw), 64'(HIT_LAT));
    chk(rd_line == exp_line(10'h046), "R8 line read", rd_line, exp_line(10'h046));

    // R6: dirty eviction writes back before fetch
    acc(1, 2, 10'h06C, 16'hA5A5, 0, nw, nb);
    log_n = 0;
    acc(1, 0, 10'h0EC, 0, 0, nw, nb);
    chk(log_n == 2, "R6 dirty miss transfer count", 64'(log_n), 2);
    chk(log_we[0] == 1'b1 && log_addr[0] == 8'h1B, "R6 write-back first", {log_we[0], log_addr[0]}, {1'b1, 8'h1B});
    chk(log_we[1] == 1'b0 && log_addr[1] == 8'h3B, "R6 fetch second", {log_we[1], log_addr[1]}, {1'b0, 8'h3B});
    chk(model_m[8'h1B] == exp_line(10'h06C), "R6 written-back data", model_m[8'h1B], exp_line(10'h06C));
    log_n = 0;
    acc(1, 0, 10'h06C, 0, 0, nw, nb);
    chk(log_n == 1 && log_we[0] == 1'b0, "R6 clean victim only fetched", 64'(log_n), 1);
    chk(rd_word == 16'hA5A5, "R7 written word survives eviction", 64'(rd_word), 64'h A5A5);

    // R7: line write then word write inside it
    acc(2, 3, 10'h140, 0, 64'h1111_2222_3333_4444, nw, nb);
    acc(2, 2, 10'h142, 16'hBEEF, 0, nw, nb);
    acc(2, 1, 10'h141, 0, 0, nw, nb);
    chk(rd_line == 64'h1111_BEEF_3333_4444, "R7 only addressed word changed", rd_line, 64'h1111_BEEF_3333_4444);

    // R2/R9: intruder during a fill, then immediate handover
    acc(0, 0, 10'h3A8, 0, 0, nw, nb);
    drive(0, 0, 10'h3C4, 0, 0);
    step(c);
    chk(c == 2'd3, "R1 owner claims with miss", 64'(c), 3);
    drive(1, 2, 10'h3A8, 16'hDEAD, 0);
    step(c);
    chk(c == 2'd2, "R2 non-owner gets WAIT", 64'(c), 2);
    drive(0, 0, 10'h3C4, 0, 0);
    finish_acc(0, 10'h3C4, 0, 0, nw, nb);
    chk(rd_word == exp_w[10'h3C4], "R8 owner read after intrusion", 64'(rd_word), 64'(exp_w[10'h3C4]));
    acc(1, 0, 10'h3A8, 0, 0, nw, nb);
    chk(nw == HIT_LAT && nb == 0, "R9 next requester claims at once", 64'(nw), 64'(HIT_LAT));
    chk(rd_word == exp_w[10'h3A8], "R2 ignored write left data", 64'(rd_word), 64'(exp_w[10'h3A8]));

    // R4: counter runs while another requester is turned away
    drive(1, 0, 10'h3A9, 0, 0);
    step(c);
    chk(c == 2'd2, "R4 latency wait", 64'(c), 2);
    drive(2, 0, 10'h3A9, 0, 0);
    step(c);
    chk(c == 2'd2, "R2 third requester waits", 64'(c), 2);
    drive(1, 0, 10'h3A9, 0, 0);
    step(c);
    chk(c == 2'd1, "R4 countdown kept running", 64'(c), 1);
    req_valid = 1'b0;

    // R5/R7/R8: sweep three colliding tags over eight lines
    for (int t = 0; t < 3; t++)
      for (int a = 0; a < 32; a++)
        acc(t % 3, 2, t*32 + a, 16'(t*4096 + a*97 + 5), 0, nw, nb);
    for (int t = 0; t < 3; t++)
      for (int a = 0; a < 32; a++) begin
        acc(a % 3, 0, t*32 + a, 0, 0, nw, nb);
        chk(rd_word == exp_w[t*32 + a], "R8 sweep read-back", 64'(rd_word), 64'(exp_w[t*32 + a]));
      end
    for (int a = 0; a < 32; a += 4) acc(0, 0, 992 + a, 0, 0, nw, nb);
    for (int l = 0; l < 24; l++)
      chk(model_m[l] == exp_line(l*4), "R6 flushed memory image", model_m[l], exp_line(l*4));

    // R5: index independence
    acc(0, 0, 10'h3E0, 0, 0, nw, nb);
    chk(nb == 0, "R5 resident line hits", 64'(nb), 0);
    acc(0, 0, 10'h000, 0, 0, nw, nb);
    chk(nb > 0, "R5 same index other tag misses", 64'(nb), 1);
    acc(0, 0, 10'h3E4, 0, 0, nw, nb);
    chk(nb == 0, "R5 other index unaffected", 64'(nb), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule